// File: doc/BRIEF.md
# PHY Management Access Unit

This unit gives software one 32-bit access word for reaching the 16-bit registers of an external Ethernet transceiver over a two-wire management bus (clause-22 MDIO). Software stores the word. That store launches a management frame. The unit then clocks the frame out on MDC and drives or releases MDIO as the frame requires.

When the frame ends, the unit reports completion through bit 31 of the same word. For a read it also places the returned value in the low half.

The two directions use opposite flag polarity, so software polls for a different value in each case:
- **Write:** software stores the word with bit 31 set and the data in bits 15:0. Bit 31 drops to 0 when the write frame has been sent.
- **Read:** software stores the word with bit 31 clear. Bit 31 rises to 1 once the data captured from the transceiver sits in bits 15:0.

The register number is taken from bits 23:16, and only its low five bits enter the frame. The transceiver address is a build-time parameter. The MDC speed is set by a divider input, captured when each frame starts.

Top module: `phy_mgmt_access`

## Requirements
- R1: After reset the access word reads 0, MDC is low and MDIO is not driven.
- R2: A store with bit 31 = 1 sends, MSB first, 32 ones, start 01, opcode 01, the 5-bit transceiver address (parameter, default 1), bits 20:16 of the word, turnaround 10, then bits 15:0 of the word, with MDIO driven on all 64 bits.
- R3: A store with bit 31 = 0 sends the same header with opcode 10 and releases MDIO (output enable low) for the two turnaround bits and the 16 data bits (frame bits 46..63 counted from 0).
- R4: On a read, MDIO is sampled at the MDC rising edge of each of the last 16 bits, MSB first. At completion these bits appear in word bits 15:0 and bit 31 reads 1, while bits 30:16 keep the stored value.
- R5: On a write, completion clears bit 31 and leaves bits 30:0 as stored.
- R6: A store made while a frame is in progress changes neither the access word nor the frame on the wire.
- R7: Each MDC half period lasts (divider + 1) clock cycles, using the divider value captured at the start of the frame. MDC stays low while no frame is in progress.
- R8: A frame has exactly 64 MDC periods. The completion flag is visible 128 × (divider + 1) cycles after the clock edge that accepted the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_wr | input | 1 | Store strobe for the access word |
| acc_wdata | input | 32 | Value stored into the access word |
| acc_rdata | output | 32 | Current access word |
| mdc_div | input | DIV_W | MDC half period minus one, in clock cycles |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A wrong bit index or a missed shift shows up as a displaced field in the captured frame, or as a read value shifted by one position. The bench sees either within the same transaction. A faulty divider or frame counter moves the completion flag away from its exact cycle count, and it also changes the number of MDC rising edges, so a single transaction exposes it. A busy store that leaks through changes the access word one cycle later, and the bench checks exactly that cycle.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int TA_POS     = 46;
    localparam int DATA_POS   = 48;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    localparam int FLAG_BIT   = 31;
    localparam int REGF_LSB   = 16;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        logic        is_write;
        logic [4:0]  reg_addr;
        logic [15:0] wdata;
    } mgmt_req_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(input mgmt_req_t r,
                                                          input logic [4:0] phy);
        mdio_op_e    op;
        logic [1:0]  ta;
        logic [15:0] body;
        op   = r.is_write ? OP_WRITE : OP_READ;
        ta   = r.is_write ? 2'b10 : 2'b11;
        body = r.is_write ? r.wdata : 16'hFFFF;
        return {{PRE_BITS{1'b1}}, 2'b01, op, phy, r.reg_addr, ta, body};
    endfunction

endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half_q;
    logic             mdc_q;
    logic             evt;

    assign evt  = run && (cnt_q == half_q);
    assign rise = evt && !mdc_q;
    assign fall = evt && mdc_q;
    assign mdc  = mdc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            half_q <= '0;
            mdc_q  <= 1'b0;
        end else if (start) begin
            cnt_q  <= '0;
            half_q <= half;
            mdc_q  <= 1'b0;
        end else if (!run) begin
            cnt_q  <= '0;
            mdc_q  <= 1'b0;
        end else if (evt) begin
            cnt_q  <= '0;
            mdc_q  <= !mdc_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R7: a toggle never happens before the half period has elapsed
    assert_half_period_R7: assert property (@(posedge clk) disable iff (rst)
        (run && !start && !evt) |=> (mdc == $past(mdc)));

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import phy_mgmt_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'd1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mgmt_req_t   req,
    input  logic        rise,
    input  logic        fall,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rdata
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] sh_q;
    logic [IDX_W-1:0]      idx_q;
    logic                  busy_q;
    logic                  wr_q;
    logic [15:0]           rdata_q;

    assign busy    = busy_q;
    assign done    = busy_q && fall && (idx_q == LAST_IDX);
    assign mdio_o  = busy_q ? sh_q[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = busy_q && (wr_q || (int'(idx_q) < TA_POS));
    assign rdata   = rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            idx_q   <= '0;
            busy_q  <= 1'b0;
            wr_q    <= 1'b0;
            rdata_q <= '0;
        end else if (start) begin
            sh_q    <= build_frame(req, PHY_ADDR);
            idx_q   <= '0;
            busy_q  <= 1'b1;
            wr_q    <= req.is_write;
        end else if (busy_q) begin
            if (rise && !wr_q && (int'(idx_q) >= DATA_POS))
                rdata_q <= {rdata_q[14:0], mdio_i};
            if (fall) begin
                if (idx_q == LAST_IDX) begin
                    busy_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                    sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end

    // R2: preamble bits are driven high
    assert_preamble_high_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && int'(idx_q) < PRE_BITS) |-> (mdio_o && mdio_oe));

    // R3: bus released from turnaround on during a read
    assert_read_release_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_q && int'(idx_q) >= TA_POS) |-> !mdio_oe);

    // R8: the frame ends after the last bit
    assert_done_ends_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: rtl/phy_mgmt_access.sv
module phy_mgmt_access
    import phy_mgmt_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'd1,
    parameter int         DIV_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_wr,
    input  logic [31:0]      acc_wdata,
    output logic [31:0]      acc_rdata,
    input  logic [DIV_W-1:0] mdc_div,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic [31:0] acc_q;
    logic        busy;
    logic        done;
    logic        start;
    logic        rise;
    logic        fall;
    logic [15:0] rdata;
    mgmt_req_t   req;

    assign start        = acc_wr && !busy;
    assign req.is_write = acc_wdata[FLAG_BIT];
    assign req.reg_addr = acc_wdata[REGF_LSB +: 5];
    assign req.wdata    = acc_wdata[15:0];
    assign acc_rdata    = acc_q;

    mdc_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .run   (busy),
        .half  (mdc_div),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    mdio_shifter #(.PHY_ADDR(PHY_ADDR)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .req     (req),
        .rise    (rise),
        .fall    (fall),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .done    (done),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rdata   (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (start) begin
            acc_q <= acc_wdata;
        end else if (done) begin
            if (acc_q[FLAG_BIT]) begin
                acc_q[FLAG_BIT] <= 1'b0;
            end else begin
                acc_q[FLAG_BIT] <= 1'b1;
                acc_q[15:0]     <= rdata;
            end
        end
    end

    // R6: stores during a frame leave the word alone
    assert_busy_store_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && acc_wr && !done) |=> (acc_rdata == $past(acc_rdata)));

    // R5: write completion drops the flag
    assert_write_flag_low_R5: assert property (@(posedge clk) disable iff (rst)
        (done && acc_rdata[FLAG_BIT]) |=> !acc_rdata[FLAG_BIT]);

    // R4: read completion raises the flag
    assert_read_flag_high_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !acc_rdata[FLAG_BIT]) |=> acc_rdata[FLAG_BIT]);

    // R7: management clock parked low when idle
    assert_mdc_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

endmodule

// File: tb/phy_mgmt_access_tb.sv
module phy_mgmt_access_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_wr = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [7:0]  mdc_div = '0;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int errors = 0;
    int checks = 0;

    always #2 clk = !clk;

    phy_mgmt_access u_dut (
        .clk       (clk),
        .rst       (rst),
        .acc_wr    (acc_wr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .mdc_div   (mdc_div),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    // transceiver model
    int          rise_cnt = 0;
    logic [63:0] cap_bits = '0;
    logic [63:0] cap_oe   = '0;
    logic [15:0] phy_val  = '0;

    always @(posedge mdc) begin
        cap_bits = {cap_bits[62:0], mdio_o};
        cap_oe   = {cap_oe[62:0], mdio_oe};
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge mdc) begin
        if (rise_cnt >= 48 && rise_cnt < 64) mdio_i = phy_val[63 - rise_cnt];
        else                                 mdio_i = 1'b1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    typedef struct {
        logic [31:0] exp_reg;
        logic [63:0] exp_frame;
        logic [63:0] exp_oe;
        int          exp_cyc;
        bit          is_wr;
    } item_t;

    item_t       sb_q[$];
    event        txn_done;
    int          act_cyc;
    logic [31:0] act_reg;
    int          act_rises;
    logic [63:0] act_bits;
    logic [63:0] act_oe;

    // monitor
    initial begin
        forever begin
            item_t it;
            @(txn_done);
            it = sb_q.pop_front();
            check(act_reg == it.exp_reg, it.is_wr ? "R5" : "R4", "access word",
                  64'(act_reg), 64'(it.exp_reg));
            check(act_cyc == it.exp_cyc, "R8", "cycles to flag",
                  64'(act_cyc), 64'(it.exp_cyc));
            check(act_rises == 64, "R8", "MDC periods", 64'(act_rises), 64'd64);
            check((act_bits & it.exp_oe) == (it.exp_frame & it.exp_oe),
                  it.is_wr ? "R2" : "R3", "frame bits",
                  act_bits & it.exp_oe, it.exp_frame & it.exp_oe);
            check(act_oe == it.exp_oe, it.is_wr ? "R2" : "R3", "drive enable",
                  act_oe, it.exp_oe);
        end
    end

    // driver
    task automatic run_txn(input logic [31:0] word, input int div,
                           input logic [15:0] pval, input bit poke);
        item_t it;
        int    n;
        bit    wr;
        wr           = word[31];
        it.is_wr     = wr;
        it.exp_reg   = wr ? {1'b0, word[30:0]} : {1'b1, word[30:16], pval};
        it.exp_frame = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), 5'd1,
                        word[20:16], (wr ? 2'b10 : 2'b00), (wr ? word[15:0] : 16'h0)};
        it.exp_oe    = wr ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF_FFFC_0000;
        it.exp_cyc   = 128 * (div + 1);
        sb_q.push_back(it);

        @(negedge clk);
        rise_cnt  = 0;
        phy_val   = pval;
        mdc_div   = 8'(div);
        acc_wr    = 1'b1;
        acc_wdata = word;
        @(negedge clk);
        acc_wr    = 1'b0;
        mdc_div   = 8'hFF;
        n = 0;
        while (n < 5000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (poke && n == 11)
                check(acc_rdata == word, "R6", "word after busy store",
                      64'(acc_rdata), 64'(word));
            if (poke && n == 10) begin
                acc_wr    = 1'b1;
                acc_wdata = ~word;
            end else begin
                acc_wr = 1'b0;
            end
            if (acc_rdata[31] != wr) break;
        end
        act_cyc   = n;
        act_reg   = acc_rdata;
        act_rises = rise_cnt;
        act_bits  = cap_bits;
        act_oe    = cap_oe;
        ->txn_done;
        @(negedge clk);
        check(mdc == 1'b0, "R7", "MDC idle level", 64'(mdc), 64'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(acc_rdata == 32'h0, "R1", "reset word", 64'(acc_rdata), 64'd0);
        check(mdc == 1'b0, "R1", "reset MDC", 64'(mdc), 64'd0);
        check(mdio_oe == 1'b0, "R1", "reset drive", 64'(mdio_oe), 64'd0);

        run_txn(32'h8000_A5C3, 0, 16'h0000, 1'b0);  // R2 write, fastest MDC
        run_txn(32'h00E5_0000, 2, 16'h1234, 1'b0);  // R3 R4 read, reg low bits 5
        run_txn(32'h803F_8001, 3, 16'h0000, 1'b1);  // R6 store during write
        run_txn(32'h0011_0000, 1, 16'hFFFF, 1'b0);  // R4 all ones
        run_txn(32'h0002_0000, 0, 16'h8001, 1'b1);  // R6 store during read
        run_txn(32'h8007_0000, 1, 16'h0000, 1'b0);  // R5 zero data write

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule